// File: doc/BRIEF.md
# Two-Tone Data Signal Modulator

This block turns a single data bit into a frequency-shift-keyed square wave. Two carrier stages, each a J-K flip-flop with its K input tied high, advance only on single-cycle enable pulses that come from their own programmable dividers on the shared system clock. The data bit gates the J input of tone stage A, and its inverse gates the J input of tone stage B. A stage whose J is high toggles on every one of its enable pulses. A stage whose J is low falls to zero on its next pulse. The output is the OR of the two stages, so the tone changes with the data and needs no multiplexer.

The data bit comes from one of two sources, chosen by a select input. The first is an internal square-wave generator with 50% duty, used for self-test. The second is an external input that passes through a two-flop synchronizer. With a 16 MHz system clock and the default divider counts (16, 32 and 256), tone A has a 2 us period, tone B has a 4 us period, and the internal data period is 16 us.

Top module: `fsk_tone_mod`

## Requirements
- R1: `rst` is a synchronous, active-high reset. After a clock edge with `rst` high, `tone_a_o`, `tone_b_o`, `mod_o` and `data_o` are all 0, whatever the state of the other inputs.
- R2: While `data_o` is 1, `tone_a_o` inverts on every TONE_A_DIV-th clock edge. It stays high for TONE_A_DIV cycles and has a period of 2*TONE_A_DIV cycles. Between its enable pulses it does not change.
- R3: While `data_o` is 0, `tone_b_o` inverts on every TONE_B_DIV-th clock edge. It has a period of 2*TONE_B_DIV cycles and does not change between its enable pulses.
- R4: A stage whose J input is 0 goes to 0 on its next enable pulse (J=0, K=1 clears). After `data_o` falls, `tone_a_o` is 0 within TONE_A_DIV cycles. After `data_o` rises, `tone_b_o` is 0 within TONE_B_DIV cycles. The disabled stage then stays 0 for as long as the data holds.
- R5: `mod_o` equals `tone_a_o | tone_b_o` in every cycle. Every rising edge of `mod_o` comes from a rising edge of one of the stages.
- R6: With `use_ext` = 0, `data_o` is the internal generator. The generator is 0 after reset and rises on the DATA_DIV/2-th clock edge after reset is released. From then on it alternates between DATA_DIV/2 cycles high and DATA_DIV/2 cycles low.
- R7: With `use_ext` = 1, `data_o` takes the value `ext_data` had two clock edges earlier.
- R8: With the data held steady, the rising edges of `mod_o` are 2*TONE_A_DIV cycles apart while data is 1, and 2*TONE_B_DIV cycles apart while data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| use_ext | input | 1 | 1 selects the synchronized external data; 0 selects the internal generator |
| ext_data | input | 1 | External data bit, asynchronous to `clk` |
| data_o | output | 1 | Data bit currently driving the stages |
| tone_a_o | output | 1 | Output of tone stage A (J = data) |
| tone_b_o | output | 1 | Output of tone stage B (J = inverted data) |
| mod_o | output | 1 | Modulated output, OR of both stages |

## Verification
The bench holds the external data high and then low, and measures the distance between rising edges of `mod_o` and the high width of each stage. A stage that loaded J instead of toggling would stay stuck high. A divider off by one would move the period by two cycles. Across each data change, the bench checks that the stage being switched off reaches zero within one of its own divider periods and stays there; a stage that merely held its value would leave a stuck-high output ORed into the tone. The bench also times the synchronizer latency to the exact edge, measures the internal generator's first rise and its half-periods, and pulses reset in the middle of operation to confirm that every output clears.

// File: rtl/fskm_pkg.sv
package fskm_pkg;

    // Next state of a J-K flip-flop on its enable pulse
    function automatic logic jk_next(input logic q, input logic j, input logic k);
        logic r;
        case ({j, k})
            2'b00:   r = q;
            2'b01:   r = 1'b0;
            2'b10:   r = 1'b1;
            default: r = ~q;
        endcase
        return r;
    endfunction

    typedef struct packed {
        logic q;
    } jk_state_t;

endpackage

// File: rtl/fskm_divider.sv
module fskm_divider #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) st_d.cnt = '0;
        else                  st_d.cnt = st_q.cnt + 1'b1;
        if (rst)              st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign tick_o = (st_q.cnt == LAST);
endmodule

// File: rtl/fskm_jk_stage.sv
module fskm_jk_stage
    import fskm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic j_i,
    input  logic k_i,
    output logic q_o
);
    jk_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) st_d.q = jk_next(st_q.q, j_i, k_i);
        if (rst)    st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q_o = st_q.q;
endmodule

// File: rtl/fsk_tone_mod.sv
module fsk_tone_mod #(
    parameter int TONE_A_DIV  = 16,
    parameter int TONE_B_DIV  = 32,
    parameter int DATA_DIV    = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic use_ext,
    input  logic ext_data,
    output logic data_o,
    output logic tone_a_o,
    output logic tone_b_o,
    output logic mod_o
);
    localparam int DATA_HALF = DATA_DIV / 2;
    localparam int NTONES    = 2;

    typedef struct packed {
        logic                   gen;
        logic [SYNC_STAGES-1:0] sync;
    } ctl_state_t;

    ctl_state_t       st_d, st_q;
    logic             tick_data;
    logic [NTONES-1:0] tick_tone;
    logic [NTONES-1:0] tone_q;
    logic             data_sel;

    fskm_divider #(.DIV(DATA_HALF)) u_data_div (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick_data)
    );

    // One divider and one J-K stage per tone; stage 0 runs on data, stage 1 on its inverse
    for (genvar g = 0; g < NTONES; g++) begin : g_tone
        localparam int SDIV = (g == 0) ? TONE_A_DIV : TONE_B_DIV;

        fskm_divider #(.DIV(SDIV)) u_div (
            .clk    (clk),
            .rst    (rst),
            .tick_o (tick_tone[g])
        );

        fskm_jk_stage u_stage (
            .clk    (clk),
            .rst    (rst),
            .tick_i (tick_tone[g]),
            .j_i    ((g == 0) ? data_sel : ~data_sel),
            .k_i    (1'b1),
            .q_o    (tone_q[g])
        );
    end

    always_comb begin
        st_d      = st_q;
        if (tick_data) st_d.gen = ~st_q.gen;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], ext_data};
        if (rst)  st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign data_sel = use_ext ? st_q.sync[SYNC_STAGES-1] : st_q.gen;
    assign data_o   = data_sel;
    assign tone_a_o = tone_q[0];
    assign tone_b_o = tone_q[1];
    assign mod_o    = |tone_q;
endmodule

// File: rtl/fskm_checker.sv
module fskm_checker (
    input logic clk,
    input logic rst,
    input logic use_ext,
    input logic ext_data,
    input logic data_o,
    input logic tone_a_o,
    input logic tone_b_o,
    input logic mod_o,
    input logic tick_a,
    input logic tick_b,
    input logic tick_d,
    input logic gen_q
);
    logic [1:0] age_q;

    always_ff @(posedge clk) begin
        if (rst)              age_q <= 2'd0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!tone_a_o && !tone_b_o && !mod_o && !data_o));

    assert_a_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !tick_a |=> $stable(tone_a_o));

    assert_a_toggle_R2: assert property (@(posedge clk) disable iff (rst)
        (tick_a && data_o) |=> (tone_a_o != $past(tone_a_o)));

    assert_b_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !tick_b |=> $stable(tone_b_o));

    assert_b_toggle_R3: assert property (@(posedge clk) disable iff (rst)
        (tick_b && !data_o) |=> (tone_b_o != $past(tone_b_o)));

    assert_a_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (tick_a && !data_o) |=> !tone_a_o);

    assert_b_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (tick_b && data_o) |=> !tone_b_o);

    assert_mod_rise_R5: assert property (@(posedge clk) disable iff (rst)
        (age_q != 2'd0 && $rose(mod_o)) |-> ($rose(tone_a_o) || $rose(tone_b_o)));

    assert_gen_step_R6: assert property (@(posedge clk) disable iff (rst)
        (age_q != 2'd0 && gen_q != $past(gen_q)) |-> $past(tick_d));

    assert_sync_delay_R7: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd3 && use_ext && $past(use_ext) && $past(use_ext, 2))
            |-> (data_o == $past(ext_data, 2)));
endmodule

bind fsk_tone_mod fskm_checker u_fskm_checker (
    .clk      (clk),
    .rst      (rst),
    .use_ext  (use_ext),
    .ext_data (ext_data),
    .data_o   (data_o),
    .tone_a_o (tone_a_o),
    .tone_b_o (tone_b_o),
    .mod_o    (mod_o),
    .tick_a   (tick_tone[0]),
    .tick_b   (tick_tone[1]),
    .tick_d   (tick_data),
    .gen_q    (st_q.gen)
);

// File: tb/sim_fsk_tone_mod.sv
module sim_fsk_tone_mod;
    localparam int A_DIV = 16;
    localparam int B_DIV = 32;
    localparam int D_DIV = 256;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic use_ext = 1'b0;
    logic ext_data = 1'b0;
    logic data_o, tone_a_o, tone_b_o, mod_o;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    fsk_tone_mod #(
        .TONE_A_DIV(A_DIV), .TONE_B_DIV(B_DIV), .DATA_DIV(D_DIV), .SYNC_STAGES(2)
    ) u0 (
        .clk(clk), .rst(rst), .use_ext(use_ext), .ext_data(ext_data),
        .data_o(data_o), .tone_a_o(tone_a_o), .tone_b_o(tone_b_o), .mod_o(mod_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic pick(input int w);
        case (w)
            0:       return mod_o;
            1:       return tone_a_o;
            default: return tone_b_o;
        endcase
    endfunction

    // cycles between two consecutive rising edges of the chosen signal
    task automatic rise_gap(input int w, output int gap);
        logic p, c;
        bit   r;
        p = pick(w);
        do begin @(negedge clk); c = pick(w); r = !p && c; p = c; end while (!r);
        gap = 0;
        do begin @(negedge clk); gap++; c = pick(w); r = !p && c; p = c; end while (!r);
    endtask

    task automatic high_width(input int w, output int wid);
        logic p, c;
        bit   r;
        p = pick(w);
        do begin @(negedge clk); c = pick(w); r = !p && c; p = c; end while (!r);
        wid = 0;
        while (pick(w)) begin @(negedge clk); wid++; end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        check(!tone_a_o && !tone_b_o && !mod_o && !data_o, "R1 outputs after reset",
              int'({tone_a_o, tone_b_o, mod_o, data_o}), 0);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_internal_gen();
        int n;
        use_ext = 1'b0;
        do_reset();
        n = 0;
        repeat (D_DIV/2 - 1) begin @(negedge clk); n++; end
        check(data_o == 1'b0, "R6 data low before first rise", int'(data_o), 0);
        @(negedge clk);
        check(data_o == 1'b1, "R6 data rises at half period", int'(data_o), 1);
        n = 0;
        while (data_o) begin @(negedge clk); n++; end
        check(n == D_DIV/2, "R6 high half-period", n, D_DIV/2);
        n = 0;
        while (!data_o) begin @(negedge clk); n++; end
        check(n == D_DIV/2, "R6 low half-period", n, D_DIV/2);
    endtask

    task automatic t_tone_a();
        int g, w, errs;
        use_ext = 1'b1; ext_data = 1'b1;
        repeat (80) @(negedge clk);
        rise_gap(0, g);
        check(g == 2*A_DIV, "R8 mod period with data high", g, 2*A_DIV);
        high_width(1, w);
        check(w == A_DIV, "R2 tone A high width", w, A_DIV);
        rise_gap(1, g);
        check(g == 2*A_DIV, "R2 tone A period", g, 2*A_DIV);
        errs = 0;
        repeat (200) begin
            @(negedge clk);
            if (tone_b_o) errs++;
            if (mod_o != (tone_a_o | tone_b_o)) errs++;
        end
        check(errs == 0, "R4 R5 tone B idle and OR while data high", errs, 0);
    endtask

    task automatic t_tone_b();
        int g, errs;
        use_ext = 1'b1; ext_data = 1'b1;
        repeat (80) @(negedge clk);
        ext_data = 1'b0;
        repeat (2 + A_DIV) @(negedge clk);
        errs = 0;
        repeat (200) begin
            @(negedge clk);
            if (tone_a_o) errs++;
            if (mod_o != (tone_a_o | tone_b_o)) errs++;
        end
        check(errs == 0, "R4 R5 tone A cleared and OR while data low", errs, 0);
        rise_gap(0, g);
        check(g == 2*B_DIV, "R8 mod period with data low", g, 2*B_DIV);
        rise_gap(2, g);
        check(g == 2*B_DIV, "R3 tone B period", g, 2*B_DIV);
        ext_data = 1'b1;
        repeat (2 + B_DIV) @(negedge clk);
        errs = 0;
        repeat (100) begin @(negedge clk); if (tone_b_o) errs++; end
        check(errs == 0, "R4 tone B cleared after data rise", errs, 0);
    endtask

    task automatic t_sync();
        logic old;
        use_ext = 1'b1;
        repeat (4) @(negedge clk);
        old = data_o;
        ext_data = ~old;
        @(negedge clk);
        check(data_o == old, "R7 no change after one edge", int'(data_o), int'(old));
        @(negedge clk);
        check(data_o == ~old, "R7 change after two edges", int'(data_o), int'(~old));
    endtask

    task automatic t_mid_reset();
        use_ext = 1'b1; ext_data = 1'b1;
        repeat (50) @(negedge clk);
        do_reset();
        check(!data_o, "R1 data cleared at release", int'(data_o), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_internal_gen();
        t_tone_a();
        t_tone_b();
        t_sync();
        t_mid_reset();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule